// File: doc/BRIEF.md
# Branch Test-Bit Selector with History Flag

This block produces the one-bit test input that a microprogram sequencer uses to decide conditional skips, branches, calls and loop exits. Each microinstruction carries two small control fields. The branch field picks the condition that drives the test bit in the current cycle. The capture field picks a condition to be remembered for the next instruction.

Each field is a 3-bit code plus an invert bit. Both fields use the same table of candidates: the live ALU status bits (carry-out, zero, sign and overflow), a one-bit history flag, an external condition input, and the constants 0 and 1. The branch path is purely combinational. The test bit therefore follows the current instruction's status within the same cycle.

The capture path feeds a single register. On every rising clock edge, this register stores the chosen candidate, inverted if the capture invert bit is set. A later instruction can then branch on the previous instruction's result by choosing the history flag in its branch field.

Top module: `tcs_branch_test`

## Requirements
- R1: A synchronous active-high reset clears the history flag to 0. After reset is released, branch code 4 with invert 0 yields test 0.
- R2: With branch codes 0, 1, 2 and 3, the test bit equals the live carry, zero, sign and overflow input respectively, in the same cycle.
- R3: With branch code 4, the test bit equals the history flag.
- R4: With branch codes 5, 6 and 7, the test bit is the external input, constant 0 and constant 1 respectively.
- R5: When the branch invert bit is 1, the test bit is the complement of the candidate chosen by the branch code.
- R6: On each rising edge outside reset, the history flag takes the candidate chosen by the capture code. Capture codes 0, 1, 2, 3 and 5 pick carry, zero, sign, overflow and the external input.
- R7: When the capture invert bit is 1, the complement of the chosen candidate is stored.
- R8: Capture codes 6 and 7 force the flag to 0 and 1 respectively. The capture invert bit swaps these values.
- R9: Capture code 4 keeps the flag unchanged when the capture invert bit is 0, and toggles the flag when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the history flag updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the history flag |
| st_carry | input | 1 | Live ALU carry-out |
| st_zero | input | 1 | Live ALU result-is-zero |
| st_sign | input | 1 | Live ALU result most significant bit |
| st_ovf | input | 1 | Live ALU two's complement overflow |
| ext_in | input | 1 | External condition input |
| fm_sel | input | 3 | Capture code for the history flag |
| fm_inv | input | 1 | Invert applied before capture |
| bs_sel | input | 3 | Branch code for the test bit |
| bs_inv | input | 1 | Invert applied to the branch choice |
| test_o | output | 1 | Test bit to the sequencer |

## Verification
The hardest state to reach is the history flag itself. Its value is never visible on a port unless the branch field is set to code 4. Every capture case is therefore checked in two steps. The stimulus loads the flag through one capture code on one edge, then selects code 4 in the branch field on the following cycle to read the flag.

The hold and toggle behaviour of capture code 4 depends on the flag's earlier value. The stimulus first forces the flag to a known 1 with capture code 7. It then applies the hold and toggle cases over several consecutive edges, reading the flag back after each one.

A long random phase then mixes all capture and branch codes. In this phase, a history flag written by one instruction is often read by the next.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int SEL_W  = 3;
    localparam int N_COND = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        C_CARRY = 3'd0,
        C_ZERO  = 3'd1,
        C_SIGN  = 3'd2,
        C_OVF   = 3'd3,
        C_FLAG  = 3'd4,
        C_EXT   = 3'd5,
        C_LOW   = 3'd6,
        C_HIGH  = 3'd7
    } cond_e;

    typedef struct packed {
        logic carry;
        logic zero;
        logic sign;
        logic ovf;
    } status_t;

    typedef struct packed {
        cond_e sel;
        logic  inv;
    } pick_t;

    // Candidate table shared by the capture and branch selectors.
    function automatic logic [N_COND-1:0] cond_vec(status_t s, logic flag, logic ext);
        logic [N_COND-1:0] v;
        v          = '0;
        v[C_CARRY] = s.carry;
        v[C_ZERO]  = s.zero;
        v[C_SIGN]  = s.sign;
        v[C_OVF]   = s.ovf;
        v[C_FLAG]  = flag;
        v[C_EXT]   = ext;
        v[C_LOW]   = 1'b0;
        v[C_HIGH]  = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tcs_cond_mux.sv
module tcs_cond_mux #(
    parameter int N  = 8,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  cands,
    input  logic [SW-1:0] sel,
    input  logic          inv,
    output logic          y
);
    always_comb begin
        y = cands[sel] ^ inv;
    end
endmodule

// File: rtl/tcs_flag_latch.sv
module tcs_flag_latch (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/tcs_branch_test.sv
module tcs_branch_test
    import tcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_carry,
    input  logic       st_zero,
    input  logic       st_sign,
    input  logic       st_ovf,
    input  logic       ext_in,
    input  logic [2:0] fm_sel,
    input  logic       fm_inv,
    input  logic [2:0] bs_sel,
    input  logic       bs_inv,
    output logic       test_o
);
    status_t           st;
    pick_t             fm;
    pick_t             bs;
    logic              flag_q;
    logic              flag_d;
    logic [N_COND-1:0] cands;

    always_comb begin
        st.carry = st_carry;
        st.zero  = st_zero;
        st.sign  = st_sign;
        st.ovf   = st_ovf;
        fm.sel   = cond_e'(fm_sel);
        fm.inv   = fm_inv;
        bs.sel   = cond_e'(bs_sel);
        bs.inv   = bs_inv;
        cands    = cond_vec(st, flag_q, ext_in);
    end

    // Capture path: selected, optionally inverted, stored on the edge.
    tcs_cond_mux #(.N(N_COND)) u_cap_mux (
        .cands (cands),
        .sel   (fm.sel),
        .inv   (fm.inv),
        .y     (flag_d)
    );

    tcs_flag_latch u_flag (
        .clk (clk),
        .rst (rst),
        .d   (flag_d),
        .q   (flag_q)
    );

    // Branch path: combinational test bit for the sequencer.
    tcs_cond_mux #(.N(N_COND)) u_br_mux (
        .cands (cands),
        .sel   (bs.sel),
        .inv   (bs.inv),
        .y     (test_o)
    );

endmodule

// File: rtl/tcs_branch_test_chk.sv
module tcs_branch_test_chk (
    input logic       clk,
    input logic       rst,
    input logic       st_carry,
    input logic       st_zero,
    input logic       st_sign,
    input logic       st_ovf,
    input logic       ext_in,
    input logic [2:0] fm_sel,
    input logic       fm_inv,
    input logic [2:0] bs_sel,
    input logic       bs_inv,
    input logic       test_o,
    input logic       flag_q
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> !flag_q);

    // R3
    flag_obs_chk: assert property (@(posedge clk) disable iff (rst)
        (bs_sel == 3'd4 && !bs_inv) |-> test_o == flag_q);

    // R4
    const_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (bs_sel == 3'd7) |-> test_o == !bs_inv);

    // R6
    cap_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_sel == 3'd0 && !fm_inv) |=> flag_q == $past(st_carry));

    // R7
    cap_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_sel == 3'd1 && fm_inv) |=> flag_q == !$past(st_zero));

    // R8
    force_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_sel == 3'd7) |=> flag_q == !$past(fm_inv));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_sel == 3'd4 && !fm_inv) |=> $stable(flag_q));

    // R9
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (fm_sel == 3'd4 && fm_inv) |=> flag_q != $past(flag_q));

endmodule

bind tcs_branch_test tcs_branch_test_chk u_chk (.*);

// File: tb/sim_tcs_branch_test.sv
`timescale 1ns/1ps
module sim_tcs_branch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       st_carry = 1'b0, st_zero = 1'b0, st_sign = 1'b0, st_ovf = 1'b0, ext_in = 1'b0;
    logic [2:0] fm_sel = 3'd4;
    logic       fm_inv = 1'b0;
    logic [2:0] bs_sel = 3'd6;
    logic       bs_inv = 1'b0;
    logic       test_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  ref_flag = 1'b0;

    always #2 clk = ~clk;

    tcs_branch_test u0 (.*);

    function automatic bit pick(int code, bit f);
        bit tbl[8];
        tbl = '{st_carry, st_zero, st_sign, st_ovf, f, ext_in, 1'b0, 1'b1};
        return tbl[code];
    endfunction

    task automatic drive(input int fs, input bit fi, input int bsl, input bit bi,
                         input bit c, input bit z, input bit s, input bit o, input bit e);
        fm_sel = 3'(fs); fm_inv = fi; bs_sel = 3'(bsl); bs_inv = bi;
        st_carry = c; st_zero = z; st_sign = s; st_ovf = o; ext_in = e;
        #1;
    endtask

    task automatic chk(input string tag);
        bit exp;
        exp = pick(int'(bs_sel), ref_flag) ^ bs_inv;
        checks++;
        if (test_o !== exp) begin
            errors++;
            $display("FAIL %s: test_o=%b expected %b (bs=%0d inv=%b flag=%b)",
                     tag, test_o, exp, bs_sel, bs_inv, ref_flag);
        end
    endtask

    task automatic tick();
        bit nxt;
        nxt = rst ? 1'b0 : (pick(int'(fm_sel), ref_flag) ^ fm_inv);
        @(posedge clk);
        #1;
        ref_flag = nxt;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        @(posedge clk); #1;
        tick(); tick();
        rst = 1'b0;
        drive(4, 0, 4, 0, 0, 0, 0, 0, 0); chk("R1");

        // R8 force to 1, then R1 reset clears it
        drive(7, 0, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R8");
        rst = 1'b1; tick(); rst = 1'b0;
        drive(4, 0, 4, 0, 0, 0, 0, 0, 0); chk("R1");

        // R2 live status, same cycle
        drive(4, 0, 0, 0, 1, 0, 0, 0, 0); chk("R2");
        drive(4, 0, 1, 0, 0, 1, 0, 0, 0); chk("R2");
        drive(4, 0, 2, 0, 1, 1, 0, 1, 1); chk("R2");
        drive(4, 0, 3, 0, 0, 0, 0, 1, 0); chk("R2");
        // R4 external and constants
        drive(4, 0, 5, 0, 0, 0, 0, 0, 1); chk("R4");
        drive(4, 0, 6, 0, 1, 1, 1, 1, 1); chk("R4");
        drive(4, 0, 7, 0, 0, 0, 0, 0, 0); chk("R4");
        // R5 invert
        drive(4, 0, 7, 1, 0, 0, 0, 0, 0); chk("R5");
        drive(4, 0, 0, 1, 1, 0, 0, 0, 0); chk("R5");

        // R6 capture each live code, read back through code 4 (R3)
        for (int k = 0; k < 6; k++) begin
            if (k == 4) continue;
            for (int v = 0; v < 2; v++) begin
                drive(k, 0, 6, 0, (k == 0) ? v[0] : !v[0], (k == 1) ? v[0] : !v[0],
                      (k == 2) ? v[0] : !v[0], (k == 3) ? v[0] : !v[0],
                      (k == 5) ? v[0] : !v[0]);
                tick();
                drive(4, 0, 4, 0, 0, 0, 0, 0, 0); chk("R6");
            end
        end
        // R7 inverted capture
        drive(0, 1, 6, 0, 1, 0, 0, 0, 0); tick();
        drive(4, 0, 4, 0, 0, 0, 0, 0, 0); chk("R7");
        drive(2, 1, 6, 0, 0, 0, 0, 0, 0); tick();
        drive(4, 0, 4, 0, 0, 0, 0, 0, 0); chk("R7");
        // R8 forced values with invert swap
        drive(6, 0, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R8");
        drive(6, 1, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R8");
        drive(7, 1, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R8");
        drive(7, 0, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R8");
        // R9 hold then toggle
        drive(4, 0, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R9");
        tick(); chk("R9");
        drive(4, 1, 4, 0, 0, 0, 0, 0, 0); tick(); chk("R9");
        tick(); chk("R9");
        tick(); chk("R9");

        // Random mix compared against the model every clock
        for (int n = 0; n < 3000; n++) begin
            int bsl;
            bsl = int'($urandom_range(0, 7));
            drive(int'($urandom_range(0, 7)), 1'($urandom), bsl, 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (bsl < 4)       chk("R2");
            else if (bsl == 4) chk("R3");
            else               chk("R4");
            tick();
        end
        summary();
    end
endmodule